// File: doc/BRIEF.md
# Hershey-Kiss Phase Modulation Generator

This block creates the phase-select code for a 256-tap clock phase multiplexer. When the code walks forward or backward through the taps, the edges of the selected clock arrive slightly early or late, and this spreads the output clock frequency over a band. Generation does not start until the enable from the delay-locked loop's lock detector is high. While that enable is low, the block waits in an idle state.

The frequency profile is not a plain triangle. A slope accumulator produces a triangle whose period is half the modulation period. It starts from a programmable offset and moves up or down by a programmable step. A 20-bit profile accumulator integrates this slope over each modulation period, which gives the rounded, nonlinear Hershey-Kiss shape. A first-order noise-shaping quantiser reduces the 20-bit profile to a 4-bit frequency word. An 8-bit phase accumulator then integrates that word and wraps modulo 256. The spread direction is selected as up, down or center. The block samples the selection only at the start of a modulation period.

Top module: `hk_phase_mod`

## Requirements
- R1: After reset, `phase_code` is 0 and `freq_word` is 0.
- R2: While `en` is low, `phase_code` holds its value and `freq_word` is 0. The period counter, slope, profile and residue are cleared, so generation restarts from the start of a period when `en` returns.
- R3: When enabled, the period counter steps 0, 1, ..., `period_len`-1 and then returns to 0. The half-period H is `period_len`/2, rounded down. The slope restarts at `slope_offset` on the counter values 0 and H.
- R4: The profile is cleared on counter value 0. During the first half (counter < H) it adds the current slope each cycle. During the second half it subtracts the slope. Arithmetic is modulo 2^20.
- R5: The quantiser forms the 21-bit sum of the profile and a 16-bit residue. The frequency word registers bits 19..16 of that sum, or 15 if bit 20 is set. The residue keeps bits 15..0.
- R6: Mode code 1 (down) subtracts the frequency word from the phase each cycle. Mode code 2 (center) adds the word minus 8. Codes 0 and 3 (up) add the word. All phase arithmetic is modulo 256.
- R7: The mode input is taken only on cycles where the counter is 0, or while the block is idle. A mode change in the middle of a period has no effect until the next period starts.
- R8: Within each half-period, take the position p as the counter value less H if in the second half. Away from the restart points, the slope adds `slope_step` while p < H/2 (rounded down) and subtracts it otherwise, modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Lock-detector enable; low keeps the block idle |
| mode | input | 2 | Spread mode: 0/3 up, 1 down, 2 center |
| period_len | input | 12 | Modulation period in clock cycles, at least 4 |
| slope_offset | input | 20 | Slope value at each triangle restart |
| slope_step | input | 20 | Slope increment per cycle |
| phase_code | output | 8 | Phase-select code for the tap multiplexer |
| freq_word | output | 4 | Quantised frequency word |

## Verification
Every state element takes its next value at one clock edge. The profile is quantised to `freq_word` one edge after it forms, and that word moves `phase_code` on the following edge. Consequently, a change of profile reaches the phase two edges later. A mode change that arrives mid-period shows up in the phase one edge after the counter passes 0. The bench steps a reference model once per rising edge and compares both outputs on the falling edge that follows. The directed boundary test waits the exact number of edges to the period start before it expects the new drift rate.

// File: rtl/hk_phase_mod.sv
module hk_phase_mod #(
  parameter int PROF_W  = 20,
  parameter int FREQ_W  = 4,
  parameter int PHASE_W = 8,
  parameter int CNT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [1:0]         mode,
  input  logic [CNT_W-1:0]   period_len,
  input  logic [PROF_W-1:0]  slope_offset,
  input  logic [PROF_W-1:0]  slope_step,
  output logic [PHASE_W-1:0] phase_code,
  output logic [FREQ_W-1:0]  freq_word
);
  localparam int FRAC_W = PROF_W - FREQ_W;
  localparam logic [PHASE_W-1:0] MID = PHASE_W'(1 << (FREQ_W - 1));
  localparam logic [PHASE_W-1:0] WMAX = PHASE_W'((1 << FREQ_W) - 1);
  localparam logic [1:0] M_DOWN = 2'd1, M_CENTER = 2'd2;

  logic [CNT_W-1:0]  cnt;
  logic [PROF_W-1:0] slope, prof;
  logic [FRAC_W-1:0] resid;
  logic [1:0]        mode_q;

  logic [CNT_W-1:0] half, quarter, pos;
  logic             first, restart, rising, wrap;
  logic [PROF_W:0]  sum;
  logic [PHASE_W-1:0] fw, ph_next;

  assign half    = period_len >> 1;
  assign quarter = half >> 1;
  assign first   = cnt < half;
  assign pos     = first ? cnt : cnt - half;
  assign restart = (cnt == '0) || (cnt == half);
  assign rising  = pos < quarter;
  assign wrap    = cnt == period_len - 1'b1;
  assign sum     = {1'b0, prof} + {{(FREQ_W+1){1'b0}}, resid};
  assign fw      = PHASE_W'(freq_word);

  always_comb begin
    case (mode_q)
      M_DOWN:   ph_next = phase_code - fw;
      M_CENTER: ph_next = phase_code + fw - MID;
      default:  ph_next = phase_code + fw;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      slope      <= '0;
      prof       <= '0;
      resid      <= '0;
      freq_word  <= '0;
      phase_code <= '0;
      mode_q     <= '0;
    end else if (!en) begin
      cnt       <= '0;
      slope     <= '0;
      prof      <= '0;
      resid     <= '0;
      freq_word <= '0;
      mode_q    <= mode;
    end else begin
      cnt        <= wrap ? '0 : cnt + 1'b1;
      slope      <= restart ? slope_offset : (rising ? slope + slope_step : slope - slope_step);
      prof       <= (cnt == '0) ? '0 : (first ? prof + slope : prof - slope);
      freq_word  <= sum[PROF_W] ? '1 : sum[PROF_W-1 -: FREQ_W];
      resid      <= sum[FRAC_W-1:0];
      phase_code <= ph_next;
      if (cnt == '0) mode_q <= mode;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(phase_code)); // R2
  AST_IDLE_FREQ: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> freq_word == '0); // R2
  AST_MODE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> $stable(mode_q)); // R7
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_q != M_DOWN && mode_q != M_CENTER) |=>
      PHASE_W'(phase_code - $past(phase_code)) <= WMAX); // R6
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_q == M_DOWN) |=>
      PHASE_W'($past(phase_code) - phase_code) <= WMAX); // R6
  AST_CENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode_q == M_CENTER) |=>
      PHASE_W'(phase_code - $past(phase_code) + MID) <= WMAX); // R6
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(period_len)) |-> cnt < period_len); // R3
endmodule

// File: tb/hk_phase_mod_test.sv
module hk_phase_mod_test;
  localparam int CLK_PERIOD = 10;
  localparam int MASK20 = 32'hFFFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [11:0] period_len = 12'd8;
  logic [19:0] slope_offset = '0;
  logic [19:0] slope_step = '0;
  logic [7:0]  phase_code;
  logic [3:0]  freq_word;

  hk_phase_mod uut (.clk(clk), .rst_n(rst_n), .en(en), .mode(mode),
    .period_len(period_len), .slope_offset(slope_offset), .slope_step(slope_step),
    .phase_code(phase_code), .freq_word(freq_word));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  // stimulus rows: mode, period, offset, step, cycles
  localparam int NV = 7;
  localparam int VEC [NV][5] = '{
    '{0,  64,  2000,  300, 200},
    '{1,  64,  2000,  300, 200},
    '{2,  40, 20000, 1000, 160},
    '{0,  40, 20000, 1000, 160},
    '{2,  64, 60000, 5000, 200},
    '{1,  17,  9000,  700, 120},
    '{3,   6, 70000,    0,  60}
  };

  int m_cnt, m_slope, m_prof, m_resid, m_freq, m_ph, m_mq;

  task automatic model_reset();
    m_cnt = 0; m_slope = 0; m_prof = 0; m_resid = 0; m_freq = 0; m_ph = 0; m_mq = 0;
  endtask

  task automatic model_step();
    int p, h, q, pos, sum, nfreq, nres, d, nslope, nprof, nmq, ncnt, nph;
    bit first, rst;
    if (!en) begin
      m_cnt = 0; m_slope = 0; m_prof = 0; m_resid = 0; m_freq = 0; m_mq = int'(mode);
      return;
    end
    p = int'(period_len); h = p / 2; q = h / 2;
    first = m_cnt < h;
    pos = first ? m_cnt : m_cnt - h;
    rst = (m_cnt == 0) || (m_cnt == h);
    sum = m_prof + m_resid;
    nfreq = (sum >= (1 << 20)) ? 15 : (sum >> 16);
    nres = sum % 65536;
    d = (m_mq == 1) ? -m_freq : (m_mq == 2) ? m_freq - 8 : m_freq;
    nph = (m_ph + d + 256) % 256;
    nslope = rst ? int'(slope_offset)
           : (pos < q ? m_slope + int'(slope_step) : m_slope - int'(slope_step)) & MASK20;
    nprof = (m_cnt == 0) ? 0 : (first ? m_prof + m_slope : m_prof - m_slope) & MASK20;
    nmq = (m_cnt == 0) ? int'(mode) : m_mq;
    ncnt = (m_cnt == p - 1) ? 0 : m_cnt + 1;
    m_cnt = ncnt; m_slope = nslope; m_prof = nprof; m_resid = nres;
    m_freq = nfreq; m_ph = nph; m_mq = nmq;
  endtask

  task automatic tick();
    @(posedge clk); #1; model_step(); @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base, bad, act_ph, act_fw;
    model_reset();
    #(CLK_PERIOD * 3);
    @(negedge clk);
    // R1 reset state
    check(phase_code == 8'd0, "R1 phase", int'(phase_code), 0);
    check(freq_word == 4'd0, "R1 freq", int'(freq_word), 0);
    rst_n = 1'b1;
    tick();

    // R6 center with zero profile: phase drops by 8 per cycle
    mode = 2'd2; period_len = 12'd8;
    tick();
    en = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    check(phase_code == 8'd216, "R6 center drift", int'(phase_code), 216);
    check(freq_word == 4'd0, "R5 zero profile", int'(freq_word), 0);

    // R2 idle hold
    en = 1'b0; mode = 2'd0;
    base = int'(phase_code);
    for (int i = 0; i < 4; i++) begin
      tick();
      if (phase_code != base[7:0]) break;
    end
    check(phase_code == base[7:0], "R2 idle hold", int'(phase_code), base);
    check(freq_word == 4'd0, "R2 idle freq", int'(freq_word), 0);

    // R7 mode change mid-period waits for counter 0
    en = 1'b1;
    for (int i = 0; i < 3; i++) tick();
    check(phase_code == base[7:0], "R6 up zero profile", int'(phase_code), base);
    mode = 2'd2;
    for (int i = 0; i < 6; i++) tick();
    check(phase_code == base[7:0], "R7 mode held mid-period", int'(phase_code), base);
    for (int i = 0; i < 2; i++) tick();
    check(phase_code == 8'((base - 16) & 255), "R7 mode at boundary", int'(phase_code), (base - 16) & 255);

    // table walk against reference model: R3 R4 R5 R6 R8
    en = 1'b0;
    tick(); tick();
    model_reset(); m_ph = int'(phase_code); m_mq = int'(mode);
    for (int v = 0; v < NV; v++) begin
      mode = VEC[v][0][1:0];
      period_len = VEC[v][1][11:0];
      slope_offset = VEC[v][2][19:0];
      slope_step = VEC[v][3][19:0];
      tick();
      en = 1'b1;
      bad = 0; act_ph = 0; act_fw = 0;
      for (int c = 0; c < VEC[v][4]; c++) begin
        tick();
        if (bad == 0 && (int'(phase_code) != m_ph || int'(freq_word) != m_freq)) begin
          bad = 1; act_ph = int'(phase_code); act_fw = int'(freq_word);
          $display("FAIL R3/R4/R5/R6/R8 row %0d cycle %0d: actual phase %0d freq %0d expected phase %0d freq %0d",
                   v, c, act_ph, act_fw, m_ph, m_freq);
        end
      end
      checks++;
      if (bad != 0) fails++;
      en = 1'b0;
      tick();
      check(freq_word == 4'd0, "R2 idle after row", int'(freq_word), 0);
    end

    finish_run();
  end
endmodule